// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, frame by frame, whether a received Ethernet frame is kept. It looks at the frame's 48-bit destination address, the programmed station address, and a three-field mode word. The host loads the mode word through a small register port. A write lands only while the controller is halted, which means the stop input or the suspend input is high. A separate soft-reset input clears only the broadcast-disable field. A hard reset (`rst_n` low) clears the whole mode word.

The receive side presents each destination address with a one-cycle strobe. One clock later the block reports a decision: an accept flag and a two-bit reason code. Frame acceptance follows a fixed priority:

- Promiscuous mode accepts everything.
- The all-ones broadcast address is accepted unless broadcast reception is disabled.
- Any other group address is refused, because no multicast table exists.
- An individual address is accepted only when it equals the station address and individual matching is not disabled.

A small state machine handles the reporting. It has two states. `ST_IDLE` means no decision is pending. `ST_REPORT` means a decision is on the outputs. Its transitions are:

- **T_STROBE** (`ST_IDLE` to `ST_REPORT`): taken when `da_valid` is high.
- **T_AGAIN** (`ST_REPORT` to `ST_REPORT`): taken when a strobe arrives back-to-back.
- **T_DONE** (`ST_REPORT` to `ST_IDLE`): taken when no strobe arrives.

Top module: `rx_addr_filter`

## Requirements
- R1: While hard reset (`rst_n` low) is applied and right after it is released, `mode_rd_data` is all zero and `dec_valid` is low.
- R2: The mode word places promiscuous at bit 0, broadcast-disable at bit 1 and individual-match-disable at bit 2. Bits 15..3 always read as zero, and the host must write them as zero.
- R3: A write (`mode_wr_en` high at a clock edge) updates the mode word only if `stop_flag` or `suspend_flag` is high at that edge. Otherwise the mode word is unchanged.
- R4: A high `soft_rst` at a clock edge clears only bit 1 and overrides a write in the same cycle. Raising `stop_flag` alone leaves all mode bits unchanged.
- R5: The decision comes one cycle after each strobe. `dec_valid` is high in exactly the cycle after each cycle with `da_valid` high. The decision uses the address and mode present in the strobe cycle.
- R6: With promiscuous set, every frame is accepted with reason 1, whatever its address and whatever the two disable bits hold.
- R7: The all-ones destination is accepted with reason 2 when broadcast-disable is clear. It is rejected with reason 0 when broadcast-disable is set and promiscuous is clear.
- R8: Individual match applies when the destination equals `station_addr` and the group bit `da[40]` (bit 0 of the first byte, `da[47:40]`) is zero. Such a frame is accepted with reason 3 when individual-match-disable is clear, and rejected with reason 0 when it is set.
- R9: Without promiscuous, two cases are rejected with reason 0: a destination with the group bit set that is not all ones, and an individual destination that differs from `station_addr`.
- R10: Whenever `dec_valid` is high, `dec_accept` is high exactly when `dec_reason` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset, synchronous, clears broadcast-disable |
| stop_flag | input | 1 | Controller stopped |
| suspend_flag | input | 1 | Controller suspended |
| mode_wr_en | input | 1 | Mode word write strobe |
| mode_wr_data | input | 16 | Mode word write value |
| mode_rd_data | output | 16 | Current mode word |
| station_addr | input | 48 | Programmed individual address |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first byte in bits 47..40 |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 2 | 0 reject, 1 promiscuous, 2 broadcast, 3 individual match |

## Verification
Random destination addresses almost never equal the station address or all ones. For that reason the stimulus chooses among four classes: broadcast, an exact station match, the station address with its group bit flipped, and fully random. The hardest cases combine promiscuous with both disables set, and a write that arrives in the same cycle as a soft reset. Directed writes set up the first; a dedicated sequence pulses soft reset together with a write. The random loop also issues mode writes with the halt inputs drawn at random, so ignored writes are mixed into the frame traffic.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int ADDR_W = 48;
    localparam int WORD_W = 16;
    localparam int MODE_W = 3;
    localparam int GROUP_BIT = ADDR_W - 8;

    typedef enum logic [1:0] {
        RSN_REJECT  = 2'd0,
        RSN_PROMISC = 2'd1,
        RSN_BCAST   = 2'd2,
        RSN_UNICAST = 2'd3
    } reason_e;

    typedef struct packed {
        logic no_phys;
        logic no_bcast;
        logic promisc;
    } mode_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;
endpackage

// File: rtl/rxf_mode_reg.sv
`timescale 1ns/1ps
module rxf_mode_reg
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop_flag,
    input  logic              suspend_flag,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output mode_t             mode,
    output logic [WORD_W-1:0] rd_data
);
    logic halted;
    assign halted = stop_flag | suspend_flag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (soft_rst) begin
            mode.no_bcast <= 1'b0;
        end else if (wr_en && halted) begin
            mode <= mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    assign rd_data = {{(WORD_W-MODE_W){1'b0}}, mode};

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !soft_rst) |=> $stable(mode));
    // R4
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!mode.no_bcast && $stable(mode.promisc) && $stable(mode.no_phys)));
    // R2
    resv_zero_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[WORD_W-1:MODE_W] == '0));
endmodule

// File: rtl/rxf_addr_cmp.sv
`timescale 1ns/1ps
module rxf_addr_cmp
    import rxf_pkg::*;
(
    input  logic [ADDR_W-1:0] da,
    input  logic [ADDR_W-1:0] station,
    output logic              is_bcast,
    output logic              is_group,
    output logic              is_match
);
    assign is_bcast = &da;
    assign is_group = da[GROUP_BIT];
    assign is_match = !da[GROUP_BIT] && (da == station);
endmodule

// File: rtl/rxf_decide.sv
`timescale 1ns/1ps
module rxf_decide
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   da_valid,
    input  mode_t  mode,
    input  logic   is_bcast,
    input  logic   is_group,
    input  logic   is_match,
    output logic   dec_valid,
    output logic   dec_accept,
    output logic [1:0] dec_reason
);
    state_e  state_q, state_d;
    reason_e rsn_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (da_valid) state_d = ST_REPORT;
            ST_REPORT: if (!da_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (mode.promisc)                        rsn_d = RSN_PROMISC;
        else if (is_bcast)                       rsn_d = mode.no_bcast ? RSN_REJECT : RSN_BCAST;
        else if (is_group)                       rsn_d = RSN_REJECT;
        else if (is_match && !mode.no_phys)      rsn_d = RSN_UNICAST;
        else                                     rsn_d = RSN_REJECT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_accept <= 1'b0;
            dec_reason <= RSN_REJECT;
        end else if (da_valid) begin
            dec_accept <= (rsn_d != RSN_REJECT);
            dec_reason <= rsn_d;
        end
    end

    assign dec_valid = (state_q == ST_REPORT);

    // R5
    strobe_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> dec_valid);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !dec_valid);
    // R6
    promisc_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && mode.promisc) |=> (dec_accept && dec_reason == RSN_PROMISC));
    // R9
    group_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !mode.promisc && is_group && !is_bcast) |=> !dec_accept);
    // R10
    accept_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_reason != RSN_REJECT)));
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
    import rxf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stop_flag,
    input  logic              suspend_flag,
    input  logic              mode_wr_en,
    input  logic [WORD_W-1:0] mode_wr_data,
    output logic [WORD_W-1:0] mode_rd_data,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        dec_reason
);
    mode_t mode;
    logic  is_bcast, is_group, is_match;

    rxf_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .stop_flag(stop_flag), .suspend_flag(suspend_flag),
        .wr_en(mode_wr_en), .wr_data(mode_wr_data),
        .mode(mode), .rd_data(mode_rd_data)
    );

    rxf_addr_cmp u_cmp (
        .da(da), .station(station_addr),
        .is_bcast(is_bcast), .is_group(is_group), .is_match(is_match)
    );

    rxf_decide u_dec (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .mode(mode),
        .is_bcast(is_bcast), .is_group(is_group), .is_match(is_match),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_reason(dec_reason)
    );

    // R2
    resv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_rd_data[WORD_W-1:MODE_W] == '0);
endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, stop_flag = 1'b0, suspend_flag = 1'b0;
    logic        mode_wr_en = 1'b0;
    logic [15:0] mode_wr_data = '0;
    logic [15:0] mode_rd_data;
    logic [47:0] station_addr = 48'h02_11_22_33_44_56;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_reason;

    int checks = 0, fails = 0;
    logic [2:0] exp_mode = 3'b000;
    int unsigned seed_dummy;

    always #5 clk = ~clk;

    rx_addr_filter dut (.*);

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [1:0] model_reason(input logic [2:0] m, input logic [47:0] a, input logic [47:0] s);
        if (m[0]) return 2'd1;
        if (&a) return m[1] ? 2'd0 : 2'd2;
        if (a[40]) return 2'd0;
        if (a == s && !m[2]) return 2'd3;
        return 2'd0;
    endfunction

    task automatic wr_mode(input logic [2:0] v, input bit stp, input bit sus, input bit srst);
        @(negedge clk);
        mode_wr_en = 1'b1; mode_wr_data = {13'd0, v};
        stop_flag = stp; suspend_flag = sus; soft_rst = srst;
        @(negedge clk);
        if (srst) exp_mode[1] = 1'b0;
        else if (stp || sus) exp_mode = v;
        mode_wr_en = 1'b0; stop_flag = 1'b0; suspend_flag = 1'b0; soft_rst = 1'b0;
        chk(mode_rd_data == {13'd0, exp_mode}, srst ? "R4" : "R3", 48'(mode_rd_data), 48'(exp_mode));
    endtask

    task automatic frame(input logic [47:0] a, input string req);
        logic [1:0] er;
        @(negedge clk);
        da = a; da_valid = 1'b1;
        er = model_reason(exp_mode, a, station_addr);
        @(negedge clk);
        da_valid = 1'b0; da = ~a;
        chk(dec_valid === 1'b1, "R5", 48'(dec_valid), 48'd1);
        chk(dec_reason === er, req, 48'(dec_reason), 48'(er));
        chk(dec_accept === (er != 2'd0), "R10", 48'(dec_accept), 48'(er != 2'd0));
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_0042);
        #1;
        chk(mode_rd_data == 16'd0, "R1", 48'(mode_rd_data), 48'd0);
        chk(dec_valid == 1'b0, "R1", 48'(dec_valid), 48'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_rd_data == 16'd0, "R1", 48'(mode_rd_data), 48'd0);
        chk(dec_valid == 1'b0, "R5", 48'(dec_valid), 48'd0);

        // R3: locked writes ignored, stop or suspend opens
        wr_mode(3'b111, 1'b0, 1'b0, 1'b0);
        wr_mode(3'b010, 1'b1, 1'b0, 1'b0);
        wr_mode(3'b101, 1'b0, 1'b1, 1'b0);
        // R2 readback with reserved bits zero
        chk(mode_rd_data[15:3] == 13'd0, "R2", 48'(mode_rd_data), 48'(exp_mode));
        // R6: promiscuous beats both disables
        wr_mode(3'b111, 1'b1, 1'b0, 1'b0);
        frame(48'hFFFF_FFFF_FFFF, "R6");
        frame(station_addr, "R6");
        frame(48'h0100_5E00_0001, "R6");
        // R4: stop alone leaves mode; soft reset beats write
        @(negedge clk); stop_flag = 1'b1; @(negedge clk); stop_flag = 1'b0;
        chk(mode_rd_data == 16'd7, "R4", 48'(mode_rd_data), 48'd7);
        wr_mode(3'b000, 1'b1, 1'b0, 1'b1);
        chk(mode_rd_data == 16'd5, "R4", 48'(mode_rd_data), 48'd5);
        // R7 and R8
        wr_mode(3'b000, 1'b1, 1'b0, 1'b0);
        frame(48'hFFFF_FFFF_FFFF, "R7");
        frame(station_addr, "R8");
        frame(station_addr ^ 48'h0100_0000_0000, "R9");
        frame(station_addr ^ 48'h1, "R9");
        wr_mode(3'b110, 1'b0, 1'b1, 1'b0);
        frame(48'hFFFF_FFFF_FFFF, "R7");
        frame(station_addr, "R8");
        // R5 back-to-back strobes
        @(negedge clk); da = station_addr; da_valid = 1'b1;
        @(negedge clk); da = 48'hFFFF_FFFF_FFFF;
        chk(dec_valid && dec_reason == 2'd0, "R5", 48'(dec_reason), 48'd0);
        @(negedge clk); da_valid = 1'b0;
        chk(dec_valid && dec_reason == 2'd0, "R5", 48'(dec_reason), 48'd0);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R5", 48'(dec_valid), 48'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [47:0] a;
            int cls;
            if ($urandom_range(0, 7) == 0)
                wr_mode(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0));
            cls = $urandom_range(0, 3);
            case (cls)
                0: a = 48'hFFFF_FFFF_FFFF;
                1: a = station_addr;
                2: a = station_addr | 48'h0100_0000_0000;
                default: a = {$urandom(), 16'($urandom())};
            endcase
            frame(a, exp_mode[0] ? "R6" : (cls == 0 ? "R7" : (cls == 1 ? "R8" : "R9")));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule